// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block sits on the controller side of a two-bank SDRAM. From reset until the memory is usable, it drives the command, address, bank, clock-enable and byte-mask pins. First it holds a quiet NOP period with clock-enable and both byte masks high. It then closes every bank with one precharge-all command and issues a programmable number of auto-refresh commands. Last, it loads the mode register with the burst length, burst type and CAS latency fields.

All waits are counted in controller clock cycles and set by parameters: the stable hold, the precharge period, the refresh cycle time and the mode-register settle time. When the sequence is complete, a done flag rises and stays high until the next reset. From then on the pins idle with NOP, and the normal memory controller takes over the bus. Every timing parameter must be at least 2, and the refresh count must be at least 2.

Top module: `sdram_bringup`

## Requirements
- R1: While reset is asserted the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), cke=1, dqm=2'b11 and init_done=0.
- R2: Counting the first cycle after reset release as cycle 0, cycles 0 to HOLD_CYC-1 carry NOP, and cycle HOLD_CYC carries the precharge-all command.
- R3: Precharge-all is encoded cs_n=0, ras_n=0, cas_n=1, we_n=0 with mem_addr[10]=1, and lasts one cycle.
- R4: The first auto-refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) occurs exactly T_RP cycles after the precharge-all.
- R5: Exactly REF_COUNT auto-refresh commands are issued, consecutive ones T_RC cycles apart.
- R6: The mode-register set (all four command pins low) occurs T_RC cycles after the last refresh, with mem_ba=0 and mem_addr[10]=0.
- R7: During the mode-register set the address carries the mode word: bits [2:0] burst length code, bit [3] burst type, bits [6:4] CAS latency code, bits [9:7] zero.
- R8: init_done rises exactly T_RSC cycles after the mode-register set and stays high. While it is high the pins show NOP with dqm=2'b00.
- R9: Every cycle other than the scheduled commands carries NOP, and cke stays high throughout.
- R10: Asserting reset part-way through the sequence returns the pins to the R1 state, and after release the whole schedule restarts from cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_cke | output | 1 | SDRAM clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 1 | Bank select |
| mem_addr | output | ADDR_W | Address / mode word |
| mem_dqm | output | 2 | Byte masks, upper and lower |
| init_done | output | 1 | High once the sequence has finished |

## Verification
The refresh-interval timer expiring and the refresh budget being used up fall in the same cycle once the final refresh wait ends. At that point the sequencer must pick the mode-register set over another refresh. The bench provokes this with a budget of three refreshes and checks every cycle against a schedule built from the requirements. It confirms that exactly three refreshes appear and that the mode-register set lands one refresh interval after the last. A reset applied during the refresh phase also meets a running timer, and the bench judges it by the full restart of the schedule.

// File: rtl/sdram_bringup_pkg.sv
`timescale 1ns/1ps
package sdram_bringup_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PREA,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RC,
        ST_MRS,
        ST_WAIT_RSC,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdram_cmd_t;

    localparam sdram_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdram_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdram_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdram_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_wait_timer.sv
`timescale 1ns/1ps
module sdram_wait_timer #(
    parameter int CNT_W     = 8,
    parameter int RESET_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_s;

    timer_s t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = load_val;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q.cnt <= CNT_W'(RESET_VAL);
        end else begin
            t_q <= t_d;
        end
    end

    assign expired = (t_q.cnt == '0);

    // the count never moves upward unless it is reloaded
    AST_TIMER_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> (t_q.cnt <= $past(t_q.cnt))); // R2

endmodule

// File: rtl/sdram_cmd_encode.sv
`timescale 1ns/1ps
module sdram_cmd_encode
    import sdram_bringup_pkg::*;
#(
    parameter int         ADDR_W  = 11,
    parameter logic [2:0] MODE_BL = 3'b011,
    parameter logic       MODE_BT = 1'b0,
    parameter logic [2:0] MODE_CL = 3'b011
) (
    input  init_state_e       state,
    output logic              cke,
    output sdram_cmd_t        cmd,
    output logic              ba,
    output logic [ADDR_W-1:0] addr,
    output logic [1:0]        dqm
);

    localparam int                PRE_ALL_BIT = 10;
    localparam logic [ADDR_W-1:0] MODE_WORD   = ADDR_W'({MODE_CL, MODE_BT, MODE_BL});

    always_comb begin
        cke  = 1'b1;
        cmd  = CMD_NOP;
        ba   = 1'b0;
        addr = '0;
        dqm  = 2'b11;
        case (state)
            ST_PREA: begin
                cmd               = CMD_PREA;
                addr[PRE_ALL_BIT] = 1'b1;
            end
            ST_REF:   cmd = CMD_REF;
            ST_MRS: begin
                cmd  = CMD_MRS;
                addr = MODE_WORD;
            end
            ST_READY: dqm = 2'b00;
            default:  cmd = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_bringup.sv
`timescale 1ns/1ps
module sdram_bringup
    import sdram_bringup_pkg::*;
#(
    parameter int         ADDR_W    = 11,
    parameter int         HOLD_CYC  = 25000,
    parameter int         T_RP      = 3,
    parameter int         T_RC      = 9,
    parameter int         T_RSC     = 2,
    parameter int         REF_COUNT = 2,
    parameter logic [2:0] MODE_BL   = 3'b011,
    parameter logic       MODE_BT   = 1'b0,
    parameter logic [2:0] MODE_CL   = 3'b011
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_dqm,
    output logic              init_done
);

    localparam int MAX_A   = (HOLD_CYC > T_RP) ? HOLD_CYC : T_RP;
    localparam int MAX_B   = (T_RC > T_RSC) ? T_RC : T_RSC;
    localparam int MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_ALL + 1);
    localparam int REF_W   = $clog2(REF_COUNT + 1);
    localparam int GAP_W   = CNT_W + 1;

    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] LD_RC  = CNT_W'(T_RC - 2);
    localparam logic [CNT_W-1:0] LD_RSC = CNT_W'(T_RSC - 2);
    localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_COUNT);

    typedef struct packed {
        init_state_e      st;
        logic [REF_W-1:0] refs;
    } seq_s;

    seq_s             s_d, s_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    sdram_cmd_t       cmd_w;

    sdram_wait_timer #(
        .CNT_W    (CNT_W),
        .RESET_VAL(HOLD_CYC - 1)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.st)
            ST_HOLD:     if (tmr_expired) s_d.st = ST_PREA;
            ST_PREA: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RP;
                s_d.st   = ST_WAIT_RP;
            end
            ST_WAIT_RP:  if (tmr_expired) s_d.st = ST_REF;
            ST_REF: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RC;
                s_d.refs = s_q.refs + 1'b1;
                s_d.st   = ST_WAIT_RC;
            end
            ST_WAIT_RC: begin
                if (tmr_expired) begin
                    s_d.st = (s_q.refs == REF_LAST) ? ST_MRS : ST_REF;
                end
            end
            ST_MRS: begin
                tmr_load = 1'b1;
                tmr_val  = LD_RSC;
                s_d.st   = ST_WAIT_RSC;
            end
            ST_WAIT_RSC: if (tmr_expired) s_d.st = ST_READY;
            default:     s_d.st = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= ST_HOLD;
            s_q.refs <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    sdram_cmd_encode #(
        .ADDR_W (ADDR_W),
        .MODE_BL(MODE_BL),
        .MODE_BT(MODE_BT),
        .MODE_CL(MODE_CL)
    ) u_encode (
        .state(s_q.st),
        .cke  (mem_cke),
        .cmd  (cmd_w),
        .ba   (mem_ba),
        .addr (mem_addr),
        .dqm  (mem_dqm)
    );

    assign mem_cs_n  = cmd_w.cs_n;
    assign mem_ras_n = cmd_w.ras_n;
    assign mem_cas_n = cmd_w.cas_n;
    assign mem_we_n  = cmd_w.we_n;
    assign init_done = (s_q.st == ST_READY);

    // ---------------- checker state: command spacing observed at the pins
    logic [GAP_W-1:0] gap_q;
    logic [REF_W:0]   ref_seen_q;
    logic             pin_nop, pin_prea, pin_ref, pin_mrs;

    assign pin_nop  = (cmd_w == CMD_NOP);
    assign pin_prea = (cmd_w == CMD_PREA);
    assign pin_ref  = (cmd_w == CMD_REF);
    assign pin_mrs  = (cmd_w == CMD_MRS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q      <= '0;
            ref_seen_q <= '0;
        end else begin
            if (!pin_nop)           gap_q <= '0;
            else if (gap_q != '1)   gap_q <= gap_q + 1'b1;
            if (pin_ref)            ref_seen_q <= ref_seen_q + 1'b1;
        end
    end

    AST_PREA_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        pin_prea |-> (gap_q == GAP_W'(HOLD_CYC)) && mem_addr[10]); // R2
    AST_FIRST_REF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ref && ref_seen_q == '0) |-> (gap_q == GAP_W'(T_RP - 1))); // R4
    AST_REF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ref && ref_seen_q != '0) |-> (gap_q == GAP_W'(T_RC - 1))); // R5
    AST_MRS_AFTER_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mrs |-> (ref_seen_q == (REF_W+1)'(REF_COUNT)) && (gap_q == GAP_W'(T_RC - 1))); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> pin_nop && (mem_dqm == 2'b00)); // R8
    AST_MRS_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        pin_mrs |=> !init_done); // R8

endmodule

// File: tb/sdram_bringup_bench.sv
`timescale 1ns/1ps
module sdram_bringup_bench;

    localparam int H   = 6;
    localparam int RP  = 3;
    localparam int RC  = 5;
    localparam int N   = 3;
    localparam int RSC = 4;
    localparam int T_MRS  = H + RP + N * RC;
    localparam int T_DONE = T_MRS + RSC;
    localparam int RUN    = T_DONE + 6;

    // command nibble {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] NOP  = 4'b0111;
    localparam logic [3:0] PREA = 4'b0010;
    localparam logic [3:0] REF  = 4'b0001;
    localparam logic [3:0] MRS  = 4'b0000;

    // scheduled events: cycle and command
    localparam int         EV_N = 5;
    localparam int         EV_CYC [EV_N] = '{H, H + RP, H + RP + RC, H + RP + 2 * RC, T_MRS};
    localparam logic [3:0] EV_CMD [EV_N] = '{PREA, REF, REF, REF, MRS};

    // BL code 010, interleaved type, CL code 011 -> 11'h03A
    localparam logic [10:0] MODE_EXP = 11'h03A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_ba;
    logic [10:0] mem_addr;
    logic [1:0]  mem_dqm;
    logic        init_done;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sdram_bringup #(
        .ADDR_W   (11),
        .HOLD_CYC (H),
        .T_RP     (RP),
        .T_RC     (RC),
        .T_RSC    (RSC),
        .REF_COUNT(N),
        .MODE_BL  (3'b010),
        .MODE_BT  (1'b1),
        .MODE_CL  (3'b011)
    ) u_sdram_bringup (
        .clk      (clk),
        .rst_n    (rst_n),
        .mem_cke  (mem_cke),
        .mem_cs_n (mem_cs_n),
        .mem_ras_n(mem_ras_n),
        .mem_cas_n(mem_cas_n),
        .mem_we_n (mem_we_n),
        .mem_ba   (mem_ba),
        .mem_addr (mem_addr),
        .mem_dqm  (mem_dqm),
        .init_done(init_done)
    );

    function automatic logic [3:0] pins();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_reset_state(input string req);
        chk(req, "cmd", int'(pins()), int'(NOP));
        chk(req, "cke", int'(mem_cke), 1);
        chk(req, "dqm", int'(mem_dqm), 3);
        chk(req, "done", int'(init_done), 0);
    endtask

    // walk the schedule table cycle by cycle; k=0 is the first cycle after release
    task automatic walk(input int ncyc, input string phase);
        for (int k = 0; k < ncyc; k++) begin
            logic [3:0] exp_cmd;
            string      req;
            bit         rdy;
            #2;
            exp_cmd = NOP;
            req     = (k < H) ? "R2" : "R9";
            for (int i = 0; i < EV_N; i++) begin
                if (EV_CYC[i] == k) begin
                    exp_cmd = EV_CMD[i];
                    req = (i == 0) ? "R3" : (i == 1) ? "R4" : (i == EV_N - 1) ? "R6" : "R5";
                end
            end
            rdy = (k >= T_DONE);
            chk(req, {phase, " cmd"}, int'(pins()), int'(exp_cmd));
            chk("R9", {phase, " cke"}, int'(mem_cke), 1);
            chk("R8", {phase, " done"}, int'(init_done), int'(rdy));
            chk("R8", {phase, " dqm"}, int'(mem_dqm), rdy ? 0 : 3);
            if (k == H) chk("R3", {phase, " addr10"}, int'(mem_addr[10]), 1);
            if (k == T_MRS) begin
                chk("R6", {phase, " ba"}, int'(mem_ba), 0);
                chk("R7", {phase, " mode word"}, int'(mem_addr), int'(MODE_EXP));
            end
            @(negedge clk);
        end
    endtask

    initial begin
        // R1: hold reset for a few edges
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            #2;
            check_reset_state("R1");
        end
        @(negedge clk);
        rst_n = 1'b1;
        walk(RUN, "run1");

        // R10: reset in the middle of the refresh phase, then full restart
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        walk(H + RP + RC + 2, "pre-abort");
        rst_n = 1'b0;
        #2;
        check_reset_state("R10");
        @(negedge clk);
        #2;
        check_reset_state("R10");
        @(negedge clk);
        rst_n = 1'b1;
        walk(RUN, "R10 restart");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule